// File: doc/BRIEF.md
# Shadow RAM and display-register commit controller

This block sits between a host register port and a display engine. The host writes a master character RAM and a set of display registers at any time. The display side reads only a slave copy of that RAM and a display copy of those registers. A request bit starts a word-by-word copy of the master RAM into the slave RAM. While a request is pending or the copy is running, the same bit reads back as 1, so it also serves as the busy flag.

A mode bit selects when changes reach the display side. In immediate mode the copy starts on the cycle after the request, and register writes show on the display copy at once. In frame-aligned mode the copy waits for the next vertical sync rising edge. Register writes then stay in their master copies until the next sync edge moves them across. A few control bits always bypass the shadowing. A pending request can be withdrawn, but a copy that has started always finishes.

Top module: `shadow_xfer_ctrl`

## Requirements
- R1: After reset, `req_o`, `mode_o` and every display register read 0.
- R2: A control write with request=1 and mode=0, issued while idle, starts the copy on the next clock edge; `req_o` reads 1 in the cycle after the write.
- R3: A control write with request=1 and mode=1, issued while idle, leaves the request pending with `req_o`=1. The copy starts on the first vsync event after that write. A vsync event is a rising edge of `vsync_i`, passed through a two-flop synchronizer, which acts on the third clock edge that samples `vsync_i` high.
- R4: `req_o` stays 1 from the request until the last word has been copied. In immediate mode it reads 1 for exactly DEPTH cycles, then clears by itself.
- R5: A control write with request=0 while the request is pending (not yet copying) cancels it: `req_o` reads 0 on the next cycle, and later vsync events start no copy. The same write during a copy has no effect.
- R6: A control write with request=1 while a request is pending or copying is ignored and does not lengthen or restart the transfer.
- R7: The copy moves one word per clock from address 0 up to DEPTH-1. Each slave word takes the value the master word holds in the cycle it is copied. The slave read port returns `slave[sram_raddr_i]` one cycle after the address is presented, including during a copy.
- R8: With the mode bit at 0, a register write appears on `disp_regs_o` in the next cycle. Register index `i` occupies bits `[i*RW +: RW]`. Indices 0..NUM_ROWS-1 are the row registers, then come vertical position, horizontal position, screen control and digital output.
- R9: With the mode bit at 1, the shadowed bits of a written register stay unchanged until a vsync event, which copies in the latest written value. A write in the same cycle as the event waits for the following event.
- R10: Screen control bit 13 and digital-output bits 15..3 are never shadowed and follow every write in the next cycle. Digital-output bits 2..0 and the other screen-control bits are shadowed.
- R11: A control write always loads the mode bit, which `mode_o` shows. A register write in the same cycle as a mode change uses the previous mode.
- R12: In mode 1, a vsync event in the same cycle as the request write does not start the copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vsync_i | input | 1 | Vertical sync, asynchronous |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_req_i | input | 1 | Request bit written (1 post, 0 cancel) |
| ctl_mode_i | input | 1 | Mode bit written (0 immediate, 1 vsync-aligned) |
| req_o | output | 1 | Request pending or copy in progress |
| mode_o | output | 1 | Current mode bit |
| mram_we_i | input | 1 | Master RAM write strobe |
| mram_addr_i | input | AW | Master RAM write address |
| mram_wdata_i | input | DW | Master RAM write data |
| sram_raddr_i | input | AW | Slave RAM read address |
| sram_rdata_o | output | DW | Slave RAM read data, one-cycle latency |
| reg_we_i | input | 1 | Display register write strobe |
| reg_sel_i | input | SW | Display register index |
| reg_wdata_i | input | RW | Display register write data |
| disp_regs_o | output | NREG*RW | Display-side register values, flattened |

## Verification
The copy is tried from an untouched pattern in immediate mode. It is also tried with master writes behind and ahead of the copy pointer during a run, which separates a per-cycle word copy from a snapshot. Vsync-aligned requests are issued with the sync event in the request cycle and in a later cycle, which shows whether the same-cycle event is wrongly taken. Cancel is tried both before the copy and during it. Register writes are made in both modes, on a sync event cycle and on a mode-change cycle, with all-ones data, so each bypassed bit shows apart from the shadowed ones.

// File: rtl/shadow_xfer_pkg.sv
package shadow_xfer_pkg;
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_WAIT = 2'd1,
    XS_COPY = 2'd2
  } xfer_state_e;

  function automatic int vpos_idx(input int rows);
    return rows;
  endfunction
  function automatic int hpos_idx(input int rows);
    return rows + 1;
  endfunction
  function automatic int sctl_idx(input int rows);
    return rows + 2;
  endfunction
  function automatic int dout_idx(input int rows);
    return rows + 3;
  endfunction
endpackage

// File: rtl/vsync_edge_det.sv
module vsync_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic pulse_o
);
  logic [STAGES:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-1:0], async_i};
  end

  // rising edge of the synchronized level
  assign pulse_o = sync_q[STAGES-1] & ~sync_q[STAGES];
endmodule

// File: rtl/copy_engine.sv
module copy_engine
  import shadow_xfer_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vs_pulse_i,
  input  logic          ctl_we_i,
  input  logic          ctl_req_i,
  input  logic          ctl_mode_i,
  output logic          req_o,
  output logic          mode_o,
  output logic          copying_o,
  output logic [AW-1:0] copy_addr_o,
  input  logic          mram_we_i,
  input  logic [AW-1:0] mram_addr_i,
  input  logic [DW-1:0] mram_wdata_i,
  input  logic [AW-1:0] sram_raddr_i,
  output logic [DW-1:0] sram_rdata_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mst_mem [DEPTH];
  logic [DW-1:0] slv_mem [DEPTH];
  xfer_state_e   state_q;
  logic [AW-1:0] addr_q;
  logic          mode_q;
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= XS_IDLE;
      addr_q  <= '0;
      mode_q  <= 1'b0;
    end else begin
      if (ctl_we_i) mode_q <= ctl_mode_i;
      unique case (state_q)
        XS_IDLE: if (ctl_we_i && ctl_req_i) begin
          state_q <= ctl_mode_i ? XS_WAIT : XS_COPY;
          addr_q  <= '0;
        end
        XS_WAIT: begin
          // cancel beats a same-cycle sync event
          if (ctl_we_i && !ctl_req_i) state_q <= XS_IDLE;
          else if (vs_pulse_i) begin
            state_q <= XS_COPY;
            addr_q  <= '0;
          end
        end
        XS_COPY: begin
          if (addr_q == LAST) state_q <= XS_IDLE;
          else                addr_q  <= addr_q + 1'b1;
        end
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (mram_we_i) mst_mem[mram_addr_i] <= mram_wdata_i;
  end

  always_ff @(posedge clk_i) begin
    if (state_q == XS_COPY) slv_mem[addr_q] <= mst_mem[addr_q];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= slv_mem[sram_raddr_i];
  end

  assign req_o        = (state_q != XS_IDLE);
  assign mode_o       = mode_q;
  assign copying_o    = (state_q == XS_COPY);
  assign copy_addr_o  = addr_q;
  assign sram_rdata_o = rdata_q;
endmodule

// File: rtl/reg_shadow.sv
module reg_shadow #(
  parameter int          NREG      = 8,
  parameter int          RW        = 16,
  parameter int          SCTL_IDX  = 6,
  parameter int          DOUT_IDX  = 7,
  parameter logic [15:0] SCTL_MASK = 16'hDFFF,
  parameter logic [15:0] DOUT_MASK = 16'h0007,
  localparam int         SW        = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             pulse_i,
  input  logic             we_i,
  input  logic [SW-1:0]    sel_i,
  input  logic [RW-1:0]    wdata_i,
  output logic [NREG*RW-1:0] disp_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    // 1 = bit waits for the commit event in mode 1
    localparam logic [RW-1:0] SMASK = (g == SCTL_IDX) ? RW'(SCTL_MASK) :
                                      (g == DOUT_IDX) ? RW'(DOUT_MASK) : {RW{1'b1}};
    logic          hit;
    logic [RW-1:0] mst_q, dsp_q, dsp_d;

    assign hit = we_i && (sel_i == SW'(g));

    always_comb begin
      dsp_d = dsp_q;
      if (hit && !mode_i) begin
        dsp_d = wdata_i;
      end else begin
        if (pulse_i) dsp_d = (dsp_d & ~SMASK) | (mst_q & SMASK);
        if (hit)     dsp_d = (dsp_d & SMASK) | (wdata_i & ~SMASK);
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mst_q <= '0;
        dsp_q <= '0;
      end else begin
        if (hit) mst_q <= wdata_i;
        dsp_q <= dsp_d;
      end
    end

    assign disp_o[g*RW +: RW] = dsp_q;
  end
endmodule

// File: rtl/shadow_xfer_ctrl.sv
module shadow_xfer_ctrl
  import shadow_xfer_pkg::*;
#(
  parameter int          DEPTH     = 16,
  parameter int          DW        = 8,
  parameter int          NUM_ROWS  = 4,
  parameter int          RW        = 16,
  parameter logic [15:0] SCTL_MASK = 16'hDFFF,
  parameter logic [15:0] DOUT_MASK = 16'h0007,
  localparam int         AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int         NREG      = NUM_ROWS + 4,
  localparam int         SW        = $clog2(NREG)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               vsync_i,
  input  logic               ctl_we_i,
  input  logic               ctl_req_i,
  input  logic               ctl_mode_i,
  output logic               req_o,
  output logic               mode_o,
  input  logic               mram_we_i,
  input  logic [AW-1:0]      mram_addr_i,
  input  logic [DW-1:0]      mram_wdata_i,
  input  logic [AW-1:0]      sram_raddr_i,
  output logic [DW-1:0]      sram_rdata_o,
  input  logic               reg_we_i,
  input  logic [SW-1:0]      reg_sel_i,
  input  logic [RW-1:0]      reg_wdata_i,
  output logic [NREG*RW-1:0] disp_regs_o
);
  logic          vs_pulse;
  logic          copying;
  logic [AW-1:0] copy_addr;

  vsync_edge_det #(.STAGES(2)) u_vs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (vsync_i),
    .pulse_o (vs_pulse)
  );

  copy_engine #(.DEPTH(DEPTH), .DW(DW)) u_copy (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .vs_pulse_i   (vs_pulse),
    .ctl_we_i     (ctl_we_i),
    .ctl_req_i    (ctl_req_i),
    .ctl_mode_i   (ctl_mode_i),
    .req_o        (req_o),
    .mode_o       (mode_o),
    .copying_o    (copying),
    .copy_addr_o  (copy_addr),
    .mram_we_i    (mram_we_i),
    .mram_addr_i  (mram_addr_i),
    .mram_wdata_i (mram_wdata_i),
    .sram_raddr_i (sram_raddr_i),
    .sram_rdata_o (sram_rdata_o)
  );

  reg_shadow #(
    .NREG      (NREG),
    .RW        (RW),
    .SCTL_IDX  (sctl_idx(NUM_ROWS)),
    .DOUT_IDX  (dout_idx(NUM_ROWS)),
    .SCTL_MASK (SCTL_MASK),
    .DOUT_MASK (DOUT_MASK)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_o),
    .pulse_i (vs_pulse),
    .we_i    (reg_we_i),
    .sel_i   (reg_sel_i),
    .wdata_i (reg_wdata_i),
    .disp_o  (disp_regs_o)
  );
endmodule

// File: rtl/shadow_xfer_chk.sv
module shadow_xfer_chk #(
  parameter int AW       = 4,
  parameter int SW       = 3,
  parameter int RW       = 16,
  parameter int NREG     = 8,
  parameter int LAST     = 15,
  parameter int VPOS_IDX = 4,
  parameter int SCTL_IDX = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ctl_we_i,
  input logic               ctl_req_i,
  input logic               ctl_mode_i,
  input logic               req_i,
  input logic               mode_i,
  input logic               copying_i,
  input logic [AW-1:0]      copy_addr_i,
  input logic               vs_pulse_i,
  input logic               reg_we_i,
  input logic [SW-1:0]      reg_sel_i,
  input logic [RW-1:0]      reg_wdata_i,
  input logic [NREG*RW-1:0] disp_regs_i
);
  AST_IMMEDIATE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i && ctl_we_i && ctl_req_i && !ctl_mode_i) |=> copying_i); // R2

  AST_VSYNC_REQ_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i && ctl_we_i && ctl_req_i && ctl_mode_i) |=> (req_i && !copying_i)); // R12

  AST_PENDING_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !copying_i && !vs_pulse_i && !(ctl_we_i && !ctl_req_i)) |=> (req_i && !copying_i)); // R3

  AST_DONE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (copying_i && copy_addr_i == AW'(LAST)) |=> !req_i); // R4

  AST_CANCEL_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !copying_i && ctl_we_i && !ctl_req_i) |=> !req_i); // R5

  AST_NO_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (copying_i && copy_addr_i != AW'(LAST)) |=> (copying_i && copy_addr_i == $past(copy_addr_i) + 1'b1)); // R7

  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && !vs_pulse_i && reg_we_i && reg_sel_i == SW'(VPOS_IDX)) |=> $stable(disp_regs_i[VPOS_IDX*RW +: RW])); // R9

  AST_SCTL_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i == SW'(SCTL_IDX)) |=> disp_regs_i[SCTL_IDX*RW + 13] == $past(reg_wdata_i[13])); // R10
endmodule

bind shadow_xfer_ctrl shadow_xfer_chk #(
  .AW(AW), .SW(SW), .RW(RW), .NREG(NREG), .LAST(DEPTH - 1),
  .VPOS_IDX(NUM_ROWS), .SCTL_IDX(NUM_ROWS + 2)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctl_we_i    (ctl_we_i),
  .ctl_req_i   (ctl_req_i),
  .ctl_mode_i  (ctl_mode_i),
  .req_i       (req_o),
  .mode_i      (mode_o),
  .copying_i   (copying),
  .copy_addr_i (copy_addr),
  .vs_pulse_i  (vs_pulse),
  .reg_we_i    (reg_we_i),
  .reg_sel_i   (reg_sel_i),
  .reg_wdata_i (reg_wdata_i),
  .disp_regs_i (disp_regs_o)
);

// File: tb/sim_shadow_xfer_ctrl.sv
`timescale 1ns/1ps
module sim_shadow_xfer_ctrl;
  localparam int DEPTH = 16, DW = 8, ROWS = 4, RW = 16;
  localparam int AW = $clog2(DEPTH), NREG = ROWS + 4, SW = $clog2(NREG);
  localparam int VPOS = ROWS, HPOS = ROWS + 1, SCTL = ROWS + 2, DOUT = ROWS + 3;

  logic clk = 0, rst_n = 0, vsync = 0;
  logic ctl_we = 0, ctl_req = 0, ctl_mode = 0;
  logic req, mode;
  logic mram_we = 0;
  logic [AW-1:0] mram_addr = '0, sram_raddr = '0;
  logic [DW-1:0] mram_wdata = '0, sram_rdata;
  logic reg_we = 0;
  logic [SW-1:0] reg_sel = '0;
  logic [RW-1:0] reg_wdata = '0;
  logic [NREG*RW-1:0] disp;

  always #10 clk = ~clk;

  shadow_xfer_ctrl #(.DEPTH(DEPTH), .DW(DW), .NUM_ROWS(ROWS), .RW(RW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .vsync_i(vsync),
    .ctl_we_i(ctl_we), .ctl_req_i(ctl_req), .ctl_mode_i(ctl_mode),
    .req_o(req), .mode_o(mode),
    .mram_we_i(mram_we), .mram_addr_i(mram_addr), .mram_wdata_i(mram_wdata),
    .sram_raddr_i(sram_raddr), .sram_rdata_o(sram_rdata),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .disp_regs_o(disp)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int m_state, m_addr, m_mode, h0, h1, h2;
  int m_mst [DEPTH];
  int m_slv [DEPTH];
  bit m_known [DEPTH];
  int m_rdata; bit m_rknown;
  int m_rm [NREG];
  int m_rd [NREG];

  function automatic int smask(input int i);
    if (i == SCTL) return 'hDFFF;
    if (i == DOUT) return 'h0007;
    return 'hFFFF;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_addr = 0; m_mode = 0; h0 = 0; h1 = 0; h2 = 0;
      m_rknown = 0;
      for (int i = 0; i < NREG; i++) begin m_rm[i] = 0; m_rd[i] = 0; end
      for (int i = 0; i < DEPTH; i++) m_known[i] = 0;
    end else begin
      automatic bit pulse = (h1 != 0) && (h2 == 0);
      h2 = h1; h1 = h0; h0 = vsync;
      m_rdata = m_slv[sram_raddr]; m_rknown = m_known[sram_raddr];
      if (m_state == 2) begin m_slv[m_addr] = m_mst[m_addr]; m_known[m_addr] = 1; end
      for (int i = 0; i < NREG; i++) begin
        automatic bit hit = reg_we && (int'(reg_sel) == i);
        automatic int m = smask(i);
        automatic int d = m_rd[i];
        if (hit && m_mode == 0) d = reg_wdata;
        else begin
          if (pulse) d = (d & ~m) | (m_rm[i] & m);
          if (hit)   d = (d & m) | (int'(reg_wdata) & ~m);
        end
        m_rd[i] = d & 'hFFFF;
        if (hit) m_rm[i] = reg_wdata;
      end
      if (mram_we) m_mst[mram_addr] = mram_wdata;
      case (m_state)
        0: if (ctl_we && ctl_req) begin m_state = ctl_mode ? 1 : 2; m_addr = 0; end
        1: if (ctl_we && !ctl_req) m_state = 0;
           else if (pulse) begin m_state = 2; m_addr = 0; end
        default: if (m_addr == DEPTH - 1) m_state = 0; else m_addr++;
      endcase
      if (ctl_we) m_mode = ctl_mode;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) if (rst_n && !done) begin
    chk("R4 req_o", req, m_state != 0);
    chk("R11 mode_o", mode, m_mode);
    if (m_rknown) chk("R7 sram_rdata_o", sram_rdata, m_rdata);
    for (int i = 0; i < NREG; i++) chk("R8 disp_regs_o", disp[i*RW +: RW], m_rd[i]);
  end

  // ---------------- stimulus ----------------
  task automatic tick(); @(negedge clk); endtask
  task automatic ctl_wr(input bit r, input bit md);
    ctl_we = 1; ctl_req = r; ctl_mode = md; tick(); ctl_we = 0;
  endtask
  task automatic reg_wr(input int sel, input int d);
    reg_we = 1; reg_sel = SW'(sel); reg_wdata = RW'(d); tick(); reg_we = 0;
  endtask
  task automatic mst_wr(input int a, input int d);
    mram_we = 1; mram_addr = AW'(a); mram_wdata = DW'(d); tick(); mram_we = 0;
  endtask
  task automatic vs_event();  // rising edge that acts on the third edge
    vsync = 0; tick(); tick(); tick(); vsync = 1; tick(); tick(); tick();
  endtask
  function automatic int dreg(input int i); return int'(disp[i*RW +: RW]); endfunction

  initial begin
    int n;
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R1 req_o reset", req, 0);
    chk("R1 mode_o reset", mode, 0);
    chk("R1 disp reset", disp, 0);

    for (int a = 0; a < DEPTH; a++) mst_wr(a, a * 7 + 3);
    ctl_wr(1, 0);
    chk("R2 busy after immediate request", req, 1);
    n = 0;
    while (req && n < 100) begin n++; tick(); end
    chk("R4 busy cycles", n, DEPTH);
    for (int a = 0; a < DEPTH; a++) begin
      sram_raddr = AW'(a); tick();
      chk("R7 slave word", sram_rdata, (a * 7 + 3) & 'hFF);
    end

    // copy with master writes behind/ahead, cancel and re-request mid-copy
    ctl_wr(1, 0);
    sram_raddr = AW'(DEPTH - 1);
    tick(); tick();
    mst_wr(0, 'hA5);
    mst_wr(DEPTH - 1, 'h5A);
    ctl_wr(0, 0);
    chk("R5 write 0 during copy ignored", req, 1);
    ctl_wr(1, 0);
    n = 6;
    while (req && n < 100) begin n++; tick(); end
    chk("R6 re-request does not extend copy", n, DEPTH);
    sram_raddr = '0; tick(); tick();
    chk("R7 word behind pointer keeps old value", sram_rdata, 3);
    sram_raddr = AW'(DEPTH - 1); tick(); tick();
    chk("R7 word ahead of pointer takes new value", sram_rdata, 'h5A);

    // vsync event in the request cycle must not start the copy
    vsync = 0; tick(); tick(); tick();
    vsync = 1; tick(); tick();
    ctl_wr(1, 1);
    repeat (DEPTH + 4) tick();
    chk("R12 same-cycle vsync ignored", req, 1);
    mst_wr(3, 'h33);
    vs_event();
    chk("R3 copy running after vsync", req, 1);
    n = 0;
    while (req && n < 100) begin n++; tick(); end
    chk("R3 copy completes", req, 0);
    sram_raddr = AW'(3); tick(); tick();
    chk("R3 vsync copy carried data", sram_rdata, 'h33);

    // cancel while pending
    mst_wr(3, 'h44);
    ctl_wr(1, 1);
    chk("R5 pending before cancel", req, 1);
    ctl_wr(0, 1);
    chk("R5 cancel clears request", req, 0);
    vs_event();
    repeat (4) tick();
    chk("R5 no copy after cancel", req, 0);
    chk("R5 slave untouched after cancel", sram_rdata, 'h33);

    // register shadowing
    ctl_wr(0, 0);
    chk("R11 mode cleared", mode, 0);
    reg_wr(VPOS, 'h1234);
    chk("R8 immediate register write", dreg(VPOS), 'h1234);
    ctl_wr(0, 1);
    chk("R11 mode set", mode, 1);
    reg_wr(HPOS, 'hABCD);
    chk("R9 shadow held before vsync", dreg(HPOS), 0);
    vs_event();
    chk("R9 shadow committed at vsync", dreg(HPOS), 'hABCD);
    reg_wr(SCTL, 'hFFFF);
    chk("R10 screen-control bit 13 bypass", dreg(SCTL), 'h2000);
    reg_wr(DOUT, 'hFFFF);
    chk("R10 output bits bypass", dreg(DOUT), 'hFFF8);
    vsync = 0; tick(); tick(); tick();
    vsync = 1; tick(); tick();
    reg_wr(0, 'h5555);
    chk("R9 write on vsync cycle waits", dreg(0), 0);
    chk("R10 screen control committed", dreg(SCTL), 'hFFFF);
    chk("R10 output committed", dreg(DOUT), 'hFFFF);
    vs_event();
    chk("R9 write committed at next vsync", dreg(0), 'h5555);

    // mode change and register write in one cycle use the old mode
    ctl_we = 1; ctl_req = 0; ctl_mode = 0;
    reg_we = 1; reg_sel = SW'(VPOS); reg_wdata = 16'h0F0F;
    tick(); ctl_we = 0; reg_we = 0;
    chk("R11 write uses previous mode", dreg(VPOS), 'h1234);
    chk("R11 mode now 0", mode, 0);
    vs_event();
    chk("R11 pending value commits", dreg(VPOS), 'h0F0F);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule